// File: doc/BRIEF.md
# FP/Vector Context-State Tracker

This block holds the two-bit context-status fields that tell system software whether floating-point and vector register state has been touched. There are four fields: FP and vector for the host supervisor status, and FP and vector for the guest (virtual-supervisor) status. When a floating-point or vector instruction commits, or a floating-point or vector CSR is modified, the block marks the matching fields Dirty. It also raises an illegal-instruction flag when software uses a unit whose context is switched Off.

The privilege input selects which copies are involved. In the non-virtual modes (host user, host supervisor), only the host copy is checked and marked. In the virtual modes (guest user, guest supervisor), the host and guest copies are both checked for Off and both marked Dirty. The guest copy never changes from execution outside virtual mode. Software writes reach any field through a per-field write strobe.

Each field is a small state machine with the states OFF, INITIAL, CLEAN and DIRTY. It has three transitions:
- LOAD: any state moves to the written value on a write strobe.
- MARK: INITIAL, CLEAN or DIRTY moves to DIRTY on a dirty request.
- HOLD: the field keeps its value otherwise. OFF never takes MARK.

Top module: `ctxst_tracker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all four fields read Off (0). The field encoding is Off=0, Initial=1, Clean=2, Dirty=3.
- R2: When `st_we_i[k]` is high at a clock edge, field k takes `st_wdata_i[2k+1:2k]` at that edge. The field index is 0=host FP, 1=host vector, 2=guest FP, 3=guest vector.
- R3: In a non-virtual mode (`priv_i[1]`=0; host user=0, host supervisor=1), a legal FP or vector instruction commit sets the host field of that unit to Dirty at the next edge. The guest field is left unchanged.
- R4: In a virtual mode (`priv_i[1]`=1; guest user=2, guest supervisor=3), a legal commit sets both the host and the guest field of that unit to Dirty.
- R5: In a non-virtual mode, an instruction of a unit is flagged illegal in the same cycle if and only if that unit's host field is Off.
- R6: In a virtual mode, an instruction of a unit is flagged illegal in the same cycle if and only if the unit's host field or its guest field is Off.
- R7: A CSR access of a unit is flagged illegal in the same cycle when the host field is Off, or when the mode is virtual and the guest field is Off. The guest field is ignored in a non-virtual mode.
- R8: A legal CSR access with its modify input high marks fields Dirty with the same host/guest rule as a commit. A legal access with modify low changes no field.
- R9: An illegal instruction or illegal CSR access changes no field.
- R10: A write strobe on a field takes priority over a dirty request to that field in the same cycle.
- R11: The FP and vector units are independent. Activity on one unit never changes the other unit's fields, even in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 2 | Privilege: 0 host user, 1 host supervisor, 2 guest user, 3 guest supervisor |
| fp_op_i | input | 1 | FP instruction commit pulse |
| vec_op_i | input | 1 | Vector instruction commit pulse |
| fp_csr_i | input | 1 | FP CSR access pulse |
| vec_csr_i | input | 1 | Vector CSR access pulse |
| fp_csr_mod_i | input | 1 | The FP CSR access modifies state |
| vec_csr_mod_i | input | 1 | The vector CSR access modifies state |
| st_we_i | input | 4 | Per-field write strobes |
| st_wdata_i | input | 8 | Packed write values, two bits per field |
| host_fs_o | output | 2 | Host FP field |
| host_vs_o | output | 2 | Host vector field |
| guest_fs_o | output | 2 | Guest FP field |
| guest_vs_o | output | 2 | Guest vector field |
| fp_op_ill_o | output | 1 | FP instruction illegal |
| vec_op_ill_o | output | 1 | Vector instruction illegal |
| fp_csr_ill_o | output | 1 | FP CSR access illegal |
| vec_csr_ill_o | output | 1 | Vector CSR access illegal |

## Verification
The hardest case to reach is a virtual-mode operation where the host copy is usable but the guest copy is Off. A second hard case is a write strobe and a dirty request landing on the same field in the same cycle. Both need the four fields set to specific, differing values before the privilege switches. The stimulus table therefore writes the host and guest fields one at a time. It then toggles between host and guest privileges and issues commits, CSR reads and CSR modifies against those prepared states. It also issues FP and vector activity together to show that the two units are isolated.

// File: rtl/ctxst_pkg.sv
package ctxst_pkg;

    typedef enum logic [1:0] {
        CTX_OFF     = 2'd0,
        CTX_INITIAL = 2'd1,
        CTX_CLEAN   = 2'd2,
        CTX_DIRTY   = 2'd3
    } ctx_state_e;

    typedef enum logic [1:0] {
        PRIV_HU = 2'd0,
        PRIV_HS = 2'd1,
        PRIV_VU = 2'd2,
        PRIV_VS = 2'd3
    } priv_e;

    localparam int ST_W       = 2;
    localparam int NUM_UNITS  = 2;
    localparam int UNIT_FP    = 0;
    localparam int UNIT_VEC   = 1;
    localparam int NUM_COPIES = 2;
    localparam int COPY_HOST  = 0;
    localparam int COPY_GUEST = 1;
    localparam int NUM_FIELDS = NUM_UNITS * NUM_COPIES;

    function automatic logic priv_is_virtual(input priv_e p);
        return (p == PRIV_VU) || (p == PRIV_VS);
    endfunction

endpackage

// File: rtl/ctxst_field.sv
module ctxst_field
    import ctxst_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       we_i,
    input  ctx_state_e wdata_i,
    input  logic       commit_dirty_i,
    input  logic       csrmod_dirty_i,
    output ctx_state_e state_o
);

    ctx_state_e state_q;
    ctx_state_e state_d;
    logic       mark;

    // both dirty sources are kept apart up to this point and merged here
    assign mark = commit_dirty_i | csrmod_dirty_i;

    always_comb begin
        state_d = state_q;
        if (we_i) begin
            state_d = wdata_i;
        end else if (mark) begin
            unique case (state_q)
                CTX_OFF:     state_d = CTX_OFF;
                CTX_INITIAL: state_d = CTX_DIRTY;
                CTX_CLEAN:   state_d = CTX_DIRTY;
                CTX_DIRTY:   state_d = CTX_DIRTY;
                default:     state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CTX_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_o = state_q;
    end

endmodule

// File: rtl/ctxst_gate.sv
module ctxst_gate
    import ctxst_pkg::*;
(
    input  logic       virt_i,
    input  logic       op_i,
    input  logic       csr_i,
    input  logic       csr_mod_i,
    input  ctx_state_e host_st_i,
    input  ctx_state_e guest_st_i,
    output logic       op_ill_o,
    output logic       csr_ill_o,
    output logic       commit_dirty_host_o,
    output logic       commit_dirty_guest_o,
    output logic       csrmod_dirty_host_o,
    output logic       csrmod_dirty_guest_o
);

    logic host_off;
    logic guest_off;
    logic blocked;
    logic op_ok;
    logic mod_ok;

    assign host_off  = (host_st_i == CTX_OFF);
    assign guest_off = (guest_st_i == CTX_OFF);
    assign blocked   = host_off | (virt_i & guest_off);

    assign op_ill_o  = op_i & blocked;
    assign csr_ill_o = csr_i & blocked;

    assign op_ok  = op_i & ~blocked;
    assign mod_ok = csr_i & csr_mod_i & ~blocked;

    assign commit_dirty_host_o  = op_ok;
    assign commit_dirty_guest_o = op_ok & virt_i;
    assign csrmod_dirty_host_o  = mod_ok;
    assign csrmod_dirty_guest_o = mod_ok & virt_i;

endmodule

// File: rtl/ctxst_tracker.sv
module ctxst_tracker
    import ctxst_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] priv_i,
    input  logic       fp_op_i,
    input  logic       vec_op_i,
    input  logic       fp_csr_i,
    input  logic       vec_csr_i,
    input  logic       fp_csr_mod_i,
    input  logic       vec_csr_mod_i,
    input  logic [3:0] st_we_i,
    input  logic [7:0] st_wdata_i,
    output logic [1:0] host_fs_o,
    output logic [1:0] host_vs_o,
    output logic [1:0] guest_fs_o,
    output logic [1:0] guest_vs_o,
    output logic       fp_op_ill_o,
    output logic       vec_op_ill_o,
    output logic       fp_csr_ill_o,
    output logic       vec_csr_ill_o
);

    logic                 virt;
    logic [NUM_UNITS-1:0] op_v;
    logic [NUM_UNITS-1:0] csr_v;
    logic [NUM_UNITS-1:0] mod_v;
    logic [NUM_UNITS-1:0] op_ill_v;
    logic [NUM_UNITS-1:0] csr_ill_v;

    logic [NUM_COPIES-1:0][NUM_UNITS-1:0] commit_dirty;
    logic [NUM_COPIES-1:0][NUM_UNITS-1:0] csrmod_dirty;
    ctx_state_e                           st [NUM_COPIES][NUM_UNITS];

    assign virt = priv_is_virtual(priv_e'(priv_i));

    assign op_v  = {vec_op_i, fp_op_i};
    assign csr_v = {vec_csr_i, fp_csr_i};
    assign mod_v = {vec_csr_mod_i, fp_csr_mod_i};

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        ctxst_gate gate_i (
            .virt_i               (virt),
            .op_i                 (op_v[u]),
            .csr_i                (csr_v[u]),
            .csr_mod_i            (mod_v[u]),
            .host_st_i            (st[COPY_HOST][u]),
            .guest_st_i           (st[COPY_GUEST][u]),
            .op_ill_o             (op_ill_v[u]),
            .csr_ill_o            (csr_ill_v[u]),
            .commit_dirty_host_o  (commit_dirty[COPY_HOST][u]),
            .commit_dirty_guest_o (commit_dirty[COPY_GUEST][u]),
            .csrmod_dirty_host_o  (csrmod_dirty[COPY_HOST][u]),
            .csrmod_dirty_guest_o (csrmod_dirty[COPY_GUEST][u])
        );

        for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
            localparam int K = c * NUM_UNITS + u;
            ctxst_field field_i (
                .clk_i          (clk_i),
                .rst_ni         (rst_ni),
                .we_i           (st_we_i[K]),
                .wdata_i        (ctx_state_e'(st_wdata_i[K*ST_W +: ST_W])),
                .commit_dirty_i (commit_dirty[c][u]),
                .csrmod_dirty_i (csrmod_dirty[c][u]),
                .state_o        (st[c][u])
            );
        end
    end

    assign host_fs_o  = st[COPY_HOST][UNIT_FP];
    assign host_vs_o  = st[COPY_HOST][UNIT_VEC];
    assign guest_fs_o = st[COPY_GUEST][UNIT_FP];
    assign guest_vs_o = st[COPY_GUEST][UNIT_VEC];

    assign fp_op_ill_o   = op_ill_v[UNIT_FP];
    assign vec_op_ill_o  = op_ill_v[UNIT_VEC];
    assign fp_csr_ill_o  = csr_ill_v[UNIT_FP];
    assign vec_csr_ill_o = csr_ill_v[UNIT_VEC];

endmodule

// File: rtl/ctxst_tracker_chk.sv
module ctxst_tracker_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] priv_i,
    input logic       fp_op_i,
    input logic       vec_op_i,
    input logic       fp_csr_i,
    input logic       vec_csr_i,
    input logic [3:0] st_we_i,
    input logic [7:0] st_wdata_i,
    input logic [1:0] host_fs_o,
    input logic [1:0] host_vs_o,
    input logic [1:0] guest_fs_o,
    input logic [1:0] guest_vs_o,
    input logic       fp_op_ill_o,
    input logic       vec_op_ill_o,
    input logic       fp_csr_ill_o
);

    assert_reset_off_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (host_fs_o == 2'd0 && host_vs_o == 2'd0 &&
                     guest_fs_o == 2'd0 && guest_vs_o == 2'd0));

    assert_write_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_we_i[0] |=> host_fs_o == $past(st_wdata_i[1:0]));

    assert_guest_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!priv_i[1] && !st_we_i[2]) |=> $stable(guest_fs_o));

    assert_host_dirty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!priv_i[1] && fp_op_i && !fp_op_ill_o && !st_we_i[0]) |=> host_fs_o == 2'd3);

    assert_guest_dirty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (priv_i[1] && fp_op_i && !fp_op_ill_o && !st_we_i[2]) |=> guest_fs_o == 2'd3);

    assert_host_off_ill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_op_i && host_vs_o == 2'd0) |-> vec_op_ill_o);

    assert_guest_off_ill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (priv_i[1] && fp_op_i && guest_fs_o == 2'd0) |-> fp_op_ill_o);

    assert_csr_guest_ill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (priv_i[1] && fp_csr_i && guest_fs_o == 2'd0) |-> fp_csr_ill_o);

    assert_ill_no_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_op_ill_o && !st_we_i[1] && !st_we_i[3]) |=>
            ($stable(host_vs_o) && $stable(guest_vs_o)));

    assert_unit_isolation_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!vec_op_i && !vec_csr_i && !st_we_i[1] && !st_we_i[3]) |=>
            ($stable(host_vs_o) && $stable(guest_vs_o)));

endmodule

bind ctxst_tracker ctxst_tracker_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .priv_i       (priv_i),
    .fp_op_i      (fp_op_i),
    .vec_op_i     (vec_op_i),
    .fp_csr_i     (fp_csr_i),
    .vec_csr_i    (vec_csr_i),
    .st_we_i      (st_we_i),
    .st_wdata_i   (st_wdata_i),
    .host_fs_o    (host_fs_o),
    .host_vs_o    (host_vs_o),
    .guest_fs_o   (guest_fs_o),
    .guest_vs_o   (guest_vs_o),
    .fp_op_ill_o  (fp_op_ill_o),
    .vec_op_ill_o (vec_op_ill_o),
    .fp_csr_ill_o (fp_csr_ill_o)
);

// File: tb/ctxst_tracker_tb_top.sv
module ctxst_tracker_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [1:0] priv_i = 2'd0;
    logic       fp_op_i = 1'b0, vec_op_i = 1'b0, fp_csr_i = 1'b0, vec_csr_i = 1'b0;
    logic       fp_csr_mod_i = 1'b0, vec_csr_mod_i = 1'b0;
    logic [3:0] st_we_i = 4'd0;
    logic [7:0] st_wdata_i = 8'd0;
    logic [1:0] host_fs_o, host_vs_o, guest_fs_o, guest_vs_o;
    logic       fp_op_ill_o, vec_op_ill_o, fp_csr_ill_o, vec_csr_ill_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    ctxst_tracker dut_i (.*);

    // entry: {req[35:32], priv[31:30], ops[29:24] = fp_op,vec_op,fp_csr,vec_csr,fp_mod,vec_mod,
    //         we[23:20], wdata[19:12], ill[11:8] = fp_op,vec_op,fp_csr,vec_csr, fields[7:0]}
    // fields byte = {guest_vs, guest_fs, host_vs, host_fs}, Off=0 Initial=1 Clean=2 Dirty=3
    localparam int NV = 22;
    localparam logic [35:0] TBL [NV] = '{
        {4'd5,  2'd1, 6'b100000, 4'b0000, 8'h00, 4'b1000, 8'h00}, // R5 host Off
        {4'd7,  2'd1, 6'b000100, 4'b0000, 8'h00, 4'b0001, 8'h00}, // R7
        {4'd2,  2'd1, 6'b000000, 4'b0001, 8'h01, 4'b0000, 8'h01}, // R2
        {4'd3,  2'd1, 6'b100000, 4'b0000, 8'h00, 4'b0000, 8'h03}, // R3
        {4'd6,  2'd3, 6'b100000, 4'b0000, 8'h00, 4'b1000, 8'h03}, // R6 guest Off
        {4'd2,  2'd3, 6'b000000, 4'b0100, 8'h20, 4'b0000, 8'h23}, // R2
        {4'd4,  2'd2, 6'b100000, 4'b0000, 8'h00, 4'b0000, 8'h33}, // R4
        {4'd6,  2'd3, 6'b010000, 4'b0010, 8'h04, 4'b0100, 8'h37}, // R6
        {4'd3,  2'd0, 6'b010000, 4'b0000, 8'h00, 4'b0000, 8'h3F}, // R3 vector
        {4'd7,  2'd2, 6'b000100, 4'b0000, 8'h00, 4'b0001, 8'h3F}, // R7 virtual
        {4'd7,  2'd0, 6'b000100, 4'b0000, 8'h00, 4'b0000, 8'h3F}, // R7 guest ignored
        {4'd2,  2'd3, 6'b000000, 4'b1000, 8'h80, 4'b0000, 8'hBF}, // R2
        {4'd2,  2'd3, 6'b000000, 4'b0101, 8'h12, 4'b0000, 8'h9E}, // R2
        {4'd8,  2'd3, 6'b001010, 4'b0000, 8'h00, 4'b0000, 8'hBF}, // R8 virtual modify
        {4'd2,  2'd3, 6'b000000, 4'b0101, 8'h11, 4'b0000, 8'h9D}, // R2
        {4'd8,  2'd1, 6'b001000, 4'b0000, 8'h00, 4'b0000, 8'h9D}, // R8 read only
        {4'd8,  2'd1, 6'b001010, 4'b0000, 8'h00, 4'b0000, 8'h9F}, // R8 host modify
        {4'd10, 2'd2, 6'b100000, 4'b0001, 8'h02, 4'b0000, 8'hBE}, // R10
        {4'd2,  2'd3, 6'b000000, 4'b1000, 8'h00, 4'b0000, 8'h3E}, // R2
        {4'd11, 2'd3, 6'b110000, 4'b0000, 8'h00, 4'b0100, 8'h3F}, // R11
        {4'd9,  2'd2, 6'b000101, 4'b0000, 8'h00, 4'b0001, 8'h3F}, // R9
        {4'd7,  2'd1, 6'b000101, 4'b0000, 8'h00, 4'b0000, 8'h3F}  // R7
    };

    function automatic logic [7:0] fields();
        return {guest_vs_o, guest_fs_o, host_vs_o, host_fs_o};
    endfunction

    function automatic logic [3:0] ills();
        return {fp_op_ill_o, vec_op_ill_o, fp_csr_ill_o, vec_csr_ill_o};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        {fp_op_i, vec_op_i, fp_csr_i, vec_csr_i, fp_csr_mod_i, vec_csr_mod_i} = 6'd0;
        st_we_i = 4'd0;
        st_wdata_i = 8'd0;
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk_i) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        #2;
        check("R1", fields(), 8'h00);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(posedge clk_i);
        #2;
        check("R1", fields(), 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk_i);
            priv_i = TBL[i][31:30];
            {fp_op_i, vec_op_i, fp_csr_i, vec_csr_i, fp_csr_mod_i, vec_csr_mod_i} = TBL[i][29:24];
            st_we_i = TBL[i][23:20];
            st_wdata_i = TBL[i][19:12];
            #2;
            check($sformatf("R%0d ill row %0d", TBL[i][35:32], i), {4'd0, ills()}, {4'd0, TBL[i][11:8]});
            @(posedge clk_i);
            #2;
            check($sformatf("R%0d fields row %0d", TBL[i][35:32], i), fields(), TBL[i][7:0]);
            idle();
        end

        // R9: an illegal op leaves all fields untouched over idle cycles too
        @(negedge clk_i);
        priv_i = 2'd2;
        vec_op_i = 1'b1;
        #2;
        check("R9 ill", {7'd0, vec_op_ill_o}, 8'h01);
        @(posedge clk_i);
        #2;
        check("R9 fields", fields(), 8'h3F);
        idle();

        // R1: reset mid-run clears every field, then an FP op in HS is illegal
        @(negedge clk_i);
        rst_ni = 1'b0;
        @(posedge clk_i);
        #2;
        check("R1 midrun", fields(), 8'h00);
        @(negedge clk_i);
        rst_ni = 1'b1;
        priv_i = 2'd1;
        fp_op_i = 1'b1;
        #2;
        check("R1 ill after reset", {7'd0, fp_op_ill_o}, 8'h01);
        @(posedge clk_i);
        #2;
        check("R1 stays Off", fields(), 8'h00);
        idle();

        done = 1'b1;
        finish_run();
    end

endmodule